// File: doc/BRIEF.md
# Distributed DRAM Refresh Controller

This block keeps every row of one DRAM bank refreshed within a fixed retention period. A free-running period timer marks out the period in clock cycles and divides it into equal slots, one per row. A credit counter keeps track of how many row refreshes are owed. A sequencer takes owed refreshes one at a time. It asks the bank arbiter for the bank, waits for the grant, issues ACTIVATE to the row under a wrapping row pointer, holds the row open for the row-active time, and then issues PRECHARGE and waits out the precharge time.

A mode input picks one of two schedules. In distributed mode one refresh falls due at the start of every slot, so the bank is taken away only briefly and at regular times. In burst mode the whole bank falls due at the start of each period, and the rows are refreshed back to back. Throughout a row cycle the block raises a busy output so that the controller holds normal traffic off the bank. When the busy output is low, normal traffic is never held up by refresh.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During and after reset `ref_req`, `cmd_valid` and `bank_busy` are low and `cmd_op` is 2'b00. The first ACTIVATE after reset targets row 0.
- R2: `cmd_op` codes are 2'b01 for ACTIVATE and 2'b10 for PRECHARGE, each valid for one cycle. ACTIVATE is issued only in the cycle after a cycle in which both `ref_req` and `ref_gnt` were high.
- R3: PRECHARGE is issued exactly T_RAS cycles after its ACTIVATE, to the same row.
- R4: Successive ACTIVATEs target rows 0, 1, ..., ROWS-1, then 0 again.
- R5: `bank_busy` is high for exactly T_RAS+T_RP cycles, starting in the ACTIVATE cycle, and low otherwise. `ref_req` is never high while `bank_busy` is high.
- R6: In distributed mode (`burst_mode`=0) one refresh falls due every PERIOD_CYC/ROWS cycles. The first falls due in the first clock cycle after reset, so the k-th ACTIVATE of a period comes exactly PERIOD_CYC/ROWS cycles after the previous one.
- R7: In burst mode (`burst_mode`=1) all ROWS refreshes fall due at the start of each period. `ref_req` rises two cycles after a period starts, and again two cycles after each row cycle ends, for as long as refreshes are owed. ACTIVATE follows in the cycle after the grant.
- R8: Whenever the grant comes promptly, exactly ROWS refreshes are performed in each period, in either mode.
- R9: A refresh that falls due while the grant is withheld stays owed and is performed later. No owed refresh is lost.
- R10: The count of owed refreshes saturates at ROWS. Periods that pass entirely without a grant add no further owed refreshes.
- R11: Once raised, `ref_req` stays high until the cycle in which `ref_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 1 selects burst schedule, 0 selects distributed schedule |
| ref_req | output | 1 | Request for the bank to the arbiter |
| ref_gnt | input | 1 | Grant from the arbiter |
| cmd_valid | output | 1 | A DRAM command is issued this cycle |
| cmd_op | output | 2 | Command code: 01 ACTIVATE, 10 PRECHARGE, 00 none |
| cmd_row | output | $clog2(ROWS) | Row address of the command |
| bank_busy | output | 1 | Bank is held by refresh; normal traffic must wait |

## Verification
The bound checker watches the command stream on every cycle. It checks that ACTIVATE follows only a granted request, that PRECHARGE comes exactly T_RAS cycles later to the same row, that the row sequence starts at 0 and steps with wrap, that busy covers every command and never overlaps a request, and that an ungranted request is held. The scheduling properties can only be shown by the bench scenarios: slot spacing in distributed mode, the back-to-back spacing in burst mode, the count of rows per period, the recovery of refreshes owed during a withheld grant, and the ceiling on the owed count.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACT,
    ST_RAS,
    ST_PRE,
    ST_RP
  } ref_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_PRE  = 2'b10
  } ref_op_e;

endpackage

// File: rtl/ref_period_timer.sv
module ref_period_timer #(
  parameter int PERIOD_CYC = 256,
  parameter int ROWS       = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic period_start,
  output logic slot_start
);

  localparam int SLOT_CYC = PERIOD_CYC / ROWS;
  localparam int CNT_W    = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int SLOT_W   = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [CNT_W-1:0] period_cnt_q, period_cnt_d;

  always_comb begin
    if (period_cnt_q == CNT_W'(PERIOD_CYC - 1)) period_cnt_d = '0;
    else                                         period_cnt_d = period_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_cnt_q <= '0;
    else        period_cnt_q <= period_cnt_d;
  end

  assign period_start = (period_cnt_q == '0);

  generate
    if (SLOT_CYC > 1) begin : g_slot_cnt
      logic [SLOT_W-1:0] slot_cnt_q, slot_cnt_d;

      always_comb begin
        if (slot_cnt_q == SLOT_W'(SLOT_CYC - 1)) slot_cnt_d = '0;
        else                                      slot_cnt_d = slot_cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_cnt_q <= '0;
        else        slot_cnt_q <= slot_cnt_d;
      end

      assign slot_start = (slot_cnt_q == '0);
    end else begin : g_slot_every
      assign slot_start = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ref_credit.sv
module ref_credit #(
  parameter int ROWS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic period_start,
  input  logic slot_start,
  input  logic row_done,
  output logic owed_any
);

  localparam int PEND_W = $clog2(ROWS + 1);
  localparam int SUM_W  = $clog2(2 * ROWS + 1);

  logic [PEND_W-1:0] owed_q, owed_d;
  logic [SUM_W-1:0]  add_w, sum_w;
  logic              owed_en;

  always_comb begin
    add_w = '0;
    if (burst_mode && period_start)       add_w = SUM_W'(ROWS);
    else if (!burst_mode && slot_start)   add_w = SUM_W'(1);
    sum_w = SUM_W'(owed_q) + add_w - SUM_W'(row_done);
    if (sum_w > SUM_W'(ROWS)) owed_d = PEND_W'(ROWS);
    else                      owed_d = sum_w[PEND_W-1:0];
    owed_en = (add_w != '0) || row_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owed_q <= '0;
    else if (owed_en) owed_q <= owed_d;
  end

  assign owed_any = (owed_q != '0);

endmodule

// File: rtl/ref_seq.sv
module ref_seq
  import dram_ref_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   owed_any,
  input  logic                                   ref_gnt,
  output logic                                   ref_req,
  output logic                                   cmd_valid,
  output logic [1:0]                             cmd_op,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] cmd_row,
  output logic                                   bank_busy,
  output logic                                   row_done
);

  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MAXW   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int WAIT_W = $clog2(MAXW + 1);

  ref_state_e        state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              wait_en;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              row_en;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    wait_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (owed_any) state_d = ST_REQ;
      ST_REQ:  if (ref_gnt)  state_d = ST_ACT;
      ST_ACT: begin
        state_d = ST_RAS;
        wait_d  = WAIT_W'(T_RAS - 2);
        wait_en = 1'b1;
      end
      ST_RAS: begin
        if (wait_q == '0) state_d = ST_PRE;
        else begin
          wait_d  = wait_q - 1'b1;
          wait_en = 1'b1;
        end
      end
      ST_PRE: begin
        state_d = ST_RP;
        wait_d  = WAIT_W'(T_RP - 2);
        wait_en = 1'b1;
      end
      ST_RP: begin
        if (wait_q == '0) state_d = ST_IDLE;
        else begin
          wait_d  = wait_q - 1'b1;
          wait_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign row_done = (state_q == ST_RP) && (wait_q == '0);

  always_comb begin
    row_en = row_done;
    if (row_q == ROW_W'(ROWS - 1)) row_d = '0;
    else                           row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      if (wait_en) wait_q <= wait_d;
      if (row_en)  row_q  <= row_d;
    end
  end

  always_comb begin
    ref_req   = (state_q == ST_REQ);
    cmd_valid = (state_q == ST_ACT) || (state_q == ST_PRE);
    cmd_op    = OP_NONE;
    if (state_q == ST_ACT) cmd_op = OP_ACT;
    if (state_q == ST_PRE) cmd_op = OP_PRE;
    bank_busy = (state_q == ST_ACT) || (state_q == ST_RAS) ||
                (state_q == ST_PRE) || (state_q == ST_RP);
    cmd_row   = row_q;
  end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS       = 8,
  parameter int PERIOD_CYC = 256,
  parameter int T_RAS      = 4,
  parameter int T_RP       = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   burst_mode,
  output logic                                   ref_req,
  input  logic                                   ref_gnt,
  output logic                                   cmd_valid,
  output logic [1:0]                             cmd_op,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] cmd_row,
  output logic                                   bank_busy
);

  logic period_start;
  logic slot_start;
  logic row_done;
  logic owed_any;

  ref_period_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .ROWS       (ROWS)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .slot_start   (slot_start)
  );

  ref_credit #(
    .ROWS (ROWS)
  ) u_credit (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_mode   (burst_mode),
    .period_start (period_start),
    .slot_start   (slot_start),
    .row_done     (row_done),
    .owed_any     (owed_any)
  );

  ref_seq #(
    .ROWS  (ROWS),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .owed_any  (owed_any),
    .ref_gnt   (ref_gnt),
    .ref_req   (ref_req),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_row   (cmd_row),
    .bank_busy (bank_busy),
    .row_done  (row_done)
  );

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int ROWS  = 8,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   ref_req,
  input logic                                   ref_gnt,
  input logic                                   cmd_valid,
  input logic [1:0]                             cmd_op,
  input logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] cmd_row,
  input logic                                   bank_busy
);

  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int LIM    = T_RAS + T_RP + 1;
  localparam int SINCE_W = $clog2(LIM + 1);

  logic               is_act, is_pre;
  logic [SINCE_W-1:0] since_q;
  logic [ROW_W-1:0]   last_row_q, next_row;
  logic               seen_q;

  assign is_act = cmd_valid && (cmd_op == 2'b01);
  assign is_pre = cmd_valid && (cmd_op == 2'b10);
  assign next_row = (last_row_q == ROW_W'(ROWS - 1)) ? '0 : last_row_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= '0;
      last_row_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      if (is_act) begin
        since_q    <= SINCE_W'(1);
        last_row_q <= cmd_row;
        seen_q     <= 1'b1;
      end else if (since_q != '0 && since_q < SINCE_W'(LIM)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  AST_ACT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> $past(ref_req && ref_gnt)); // R2

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid ? (cmd_op == 2'b01 || cmd_op == 2'b10) : (cmd_op == 2'b00)); // R2

  AST_PRE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_q == SINCE_W'(T_RAS))); // R3

  AST_PRE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (seen_q && cmd_row == last_row_q)); // R3

  AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !seen_q) |-> (cmd_row == '0)); // R1

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && seen_q) |-> (cmd_row == next_row)); // R4

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> bank_busy); // R5

  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !bank_busy); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req); // R11

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(
  .ROWS  (ROWS),
  .T_RAS (T_RAS),
  .T_RP  (T_RP)
) u_chk (.*);

// File: tb/dram_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb;

  localparam int ROWS   = 8;
  localparam int PERIOD = 256;
  localparam int T_RAS  = 4;
  localparam int T_RP   = 3;
  localparam int SLOT   = PERIOD / ROWS;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int NSCN   = 5;

  // scenario table: mode, grant latency, expected first-ACTIVATE offset, expected ACTIVATE spacing
  localparam bit SCN_BURST [NSCN] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam int SCN_LAT   [NSCN] = '{0,    5,    0,    2,    6};
  localparam int SCN_FIRST [NSCN] = '{3,    8,    3,    5,    9};
  localparam int SCN_GAP   [NSCN] = '{32,   32,   9,    11,   15};

  logic             clk;
  logic             rst_n;
  logic             burst_mode;
  logic             ref_req;
  logic             ref_gnt;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic             bank_busy;

  dram_refresh_ctrl #(
    .ROWS       (ROWS),
    .PERIOD_CYC (PERIOD),
    .T_RAS      (T_RAS),
    .T_RP       (T_RP)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_mode (burst_mode),
    .ref_req    (ref_req),
    .ref_gnt    (ref_gnt),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_row    (cmd_row),
    .bank_busy  (bank_busy)
  );

  int  n_chk, n_fail;
  int  cyc;
  bit  mon_en, chk_timing, gnt_block, finished;
  int  gnt_lat, waited;
  int  exp_first, exp_gap;
  int  act_cnt, exp_row, last_p, last_act, pre_due, pre_row;
  bit  have_act;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      if (!rst_n) cyc = 0;
      else        cyc = cyc + 1;
    end
  end

  // monitor and grant model, all at the falling edge
  initial begin
    ref_gnt = 1'b0;
    waited  = 0;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n) begin
        if (cmd_valid && cmd_op == 2'b01) begin
          if (act_cnt == 0)
            chk(int'(cmd_row) == 0, "R1", "first row", int'(cmd_row), 0);
          chk(int'(cmd_row) == exp_row, "R4", "activate row", int'(cmd_row), exp_row);
          if (chk_timing) begin
            if (cyc / PERIOD != last_p)
              chk(cyc % PERIOD == exp_first, burst_mode ? "R7" : "R6",
                  "first activate offset", cyc % PERIOD, exp_first);
            else
              chk(cyc - last_act == exp_gap, burst_mode ? "R7" : "R6",
                  "activate spacing", cyc - last_act, exp_gap);
          end
          last_p   = cyc / PERIOD;
          last_act = cyc;
          have_act = 1'b1;
          pre_due  = cyc + T_RAS;
          pre_row  = int'(cmd_row);
          exp_row  = (exp_row + 1) % ROWS;
          act_cnt++;
        end
        if (cmd_valid && cmd_op == 2'b10) begin
          chk(cyc == pre_due, "R3", "precharge cycle", cyc, pre_due);
          chk(int'(cmd_row) == pre_row, "R3", "precharge row", int'(cmd_row), pre_row);
        end
        chk(bank_busy == (have_act && (cyc - last_act) < T_RAS + T_RP), "R5",
            "busy window", int'(bank_busy), int'(have_act && (cyc - last_act) < T_RAS + T_RP));
        if (ref_req && bank_busy)
          chk(1'b0, "R5", "request while busy", 1, 0);
      end
      if (ref_req && !gnt_block) begin
        ref_gnt = (waited >= gnt_lat);
        waited++;
      end else begin
        ref_gnt = 1'b0;
        if (!ref_req) waited = 0;
      end
    end
  end

  task automatic do_reset();
    mon_en   = 1'b0;
    @(negedge clk);
    rst_n    = 1'b0;
    act_cnt  = 0;
    exp_row  = 0;
    last_p   = -1;
    last_act = 0;
    have_act = 1'b0;
    pre_due  = -1;
    pre_row  = 0;
    repeat (3) @(negedge clk);
    chk(!ref_req && !cmd_valid && !bank_busy && cmd_op == 2'b00, "R1", "reset outputs",
        int'({ref_req, cmd_valid, bank_busy}), 0);
    rst_n  = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  initial begin
    finished   = 1'b0;
    n_chk      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    burst_mode = 1'b0;
    gnt_block  = 1'b0;
    gnt_lat    = 0;
    chk_timing = 1'b1;

    // table walk: each scenario runs two full periods
    for (int s = 0; s < NSCN; s++) begin
      burst_mode = SCN_BURST[s];
      gnt_lat    = SCN_LAT[s];
      exp_first  = SCN_FIRST[s];
      exp_gap    = SCN_GAP[s];
      chk_timing = 1'b1;
      do_reset();
      wait_until(2 * PERIOD);
      chk(act_cnt == 2 * ROWS, "R8", "refreshes in two periods", act_cnt, 2 * ROWS);
    end

    // R9: grant withheld across several slots, nothing lost
    burst_mode = 1'b0;
    gnt_lat    = 0;
    chk_timing = 1'b0;
    gnt_block  = 1'b1;
    do_reset();
    wait_until(100);
    chk(act_cnt == 0, "R9", "no activate while ungranted", act_cnt, 0);
    chk(ref_req == 1'b1, "R11", "request held", int'(ref_req), 1);
    chk(bank_busy == 1'b0, "R5", "idle while ungranted", int'(bank_busy), 0);
    gnt_block = 1'b0;
    wait_until(2 * PERIOD);
    chk(act_cnt == 2 * ROWS, "R9", "owed refreshes recovered", act_cnt, 2 * ROWS);

    // R10: three burst periods pass ungranted, owed count capped at ROWS
    burst_mode = 1'b1;
    gnt_block  = 1'b1;
    do_reset();
    wait_until(2 * PERIOD + 8);
    chk(act_cnt == 0, "R10", "no activate while ungranted", act_cnt, 0);
    gnt_block = 1'b0;
    wait_until(3 * PERIOD - 8);
    chk(act_cnt == ROWS, "R10", "refreshes after release", act_cnt, ROWS);
    wait_until(4 * PERIOD - 4);
    chk(act_cnt == 2 * ROWS, "R8", "next burst period", act_cnt, 2 * ROWS);
    chk(exp_row == 0, "R4", "row pointer wrapped", exp_row, 0);

    mon_en   = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule